// File: doc/BRIEF.md
# Binary and Decimal Add/Subtract Unit

This unit adds with carry or subtracts with borrow on an accumulator and an operand. Each operation is either 8 or 16 bits wide and uses either plain binary or packed BCD, with four bits per digit. The caller presents the accumulator, the operand, a carry input and three mode bits together with a valid strobe. One clock later the unit returns the new accumulator value and the carry, overflow, negative and zero flags.

Subtraction is done by adding the one's complement of the operand, limited to the active width. The carry input then means "no borrow". Decimal correction runs digit by digit, from the lowest digit upwards.

Decimal overflow is taken from the digit sums before correction. In 8-bit mode only the low byte of the accumulator changes, and the upper byte passes through unchanged.

Top module: `decAddSub`

## Requirements
- R1: When `inValid` is high at a rising clock edge, `outValid` is high after that edge with the results of those inputs. When `inValid` is low at an edge, `outValid` is low after it.
- R2: When `inValid` is low, `accOut` and the four flags keep their previous values.
- R3: In binary add (`decimalMode`=0, `subtract`=0), the result is the accumulator plus the operand plus `carryIn`, taken over the active width.
- R4: In subtract (`subtract`=1), the operand is replaced by its one's complement within the active width before the add. `carryIn`=1 means no borrow, and `carryOut`=1 means no borrow occurred.
- R5: In decimal add, any digit sum (two digits plus the incoming carry) of 10 or more is corrected by adding 6 modulo 16. That digit then passes a carry of 1 to the next digit. Otherwise the digit's own carry bit passes on.
- R6: In decimal subtract, a digit sum below 16 is corrected by subtracting 6 modulo 16 and passes a carry of 0. A sum of 16 or more keeps its low four bits and passes a carry of 1.
- R7: In binary mode, `overflowOut` is set when the result's top active bit differs from both the accumulator's and the adjusted operand's top active bit.
- R8: In decimal mode, the overflow rule of R7 uses the uncorrected low four bits of every digit sum in place of the result.
- R9: `carryOut` is the carry leaving digit 1 (bit 8) in 8-bit mode (`wideMode`=0) and leaving digit 3 (bit 16) in 16-bit mode (`wideMode`=1).
- R10: `negOut` is result bit 7 (8-bit) or bit 15 (16-bit), and `zeroOut` is set when the result's active bits are all zero.
- R11: In 8-bit mode, `accOut[15:8]` equals `accIn[15:8]` of the same operation.
- R12: Digits above 9 in decimal mode go through the same correction rules, and no error is flagged.
- R13: While `rstN` is low, `outValid`, `accOut` and every flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| inValid | input | 1 | Inputs are valid this cycle |
| accIn | input | 16 | Accumulator operand |
| operand | input | 16 | Second operand |
| carryIn | input | 1 | Carry in / not-borrow |
| decimalMode | input | 1 | 1 = packed BCD |
| wideMode | input | 1 | 1 = 16-bit, 0 = 8-bit |
| subtract | input | 1 | 1 = subtract with borrow |
| outValid | output | 1 | Results registered this cycle |
| accOut | output | 16 | Merged accumulator result |
| carryOut | output | 1 | Carry out |
| overflowOut | output | 1 | Signed overflow |
| negOut | output | 1 | Negative flag |
| zeroOut | output | 1 | Zero flag |

## Verification
A wrong internal state shows at the ports one cycle after the inputs are applied. The carry chain is the main risk: a bad correction or a wrong carry between digits corrupts every digit above it, and it also corrupts `carryOut`. A wrong width select shows up the same cycle in the upper byte of `accOut`, or as a carry or flag taken from the wrong bit. The behavioural model compares every output on every clock, so any difference is reported at the first cycle it appears.

// File: rtl/decAluPkg.sv
package decAluPkg;
  typedef struct packed {
    logic load;
    logic wide;
    logic decimal;
    logic sub;
  } aluStrobeT;
endpackage

// File: rtl/bcdDigit.sv
module bcdDigit (
  input  logic [3:0] aNib,
  input  logic [3:0] bNib,
  input  logic       cin,
  input  logic       decimal,
  input  logic       sub,
  output logic [3:0] rNib,
  output logic [3:0] partNib,
  output logic       cout
);
  logic [4:0] rawSum;

  assign rawSum  = {1'b0, aNib} + {1'b0, bNib} + {4'd0, cin};
  assign partNib = rawSum[3:0];

  always_comb begin
    rNib = rawSum[3:0];
    cout = rawSum[4];
    if (decimal && !sub && (rawSum >= 5'd10)) begin
      rNib = rawSum[3:0] + 4'd6;
      cout = 1'b1;
    end else if (decimal && sub && !rawSum[4]) begin
      rNib = rawSum[3:0] - 4'd6;
      cout = 1'b0;
    end
  end
endmodule

// File: rtl/aluCtrl.sv
module aluCtrl
  import decAluPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      wideMode,
  input  logic      decimalMode,
  input  logic      subtract,
  output aluStrobeT strobe,
  output logic      outValid
);
  always_comb begin
    strobe.load    = inValid;
    strobe.wide    = wideMode;
    strobe.decimal = decimalMode;
    strobe.sub     = subtract;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import decAluPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  aluStrobeT        strobe,
  input  logic [WIDTH-1:0] accIn,
  input  logic [WIDTH-1:0] operand,
  input  logic             carryIn,
  output logic [WIDTH-1:0] accOut,
  output logic             carryOut,
  output logic             overflowOut,
  output logic             negOut,
  output logic             zeroOut
);
  localparam int DIGITS  = WIDTH / 4;
  localparam int HALF    = WIDTH / 2;
  localparam int HALFDIG = DIGITS / 2;

  logic [WIDTH-1:0] widthMask, aMasked, bMasked, sumFull, partFull, ovfSrc, ovfVec;
  logic [DIGITS:0]  digitCarry;
  logic [WIDTH-1:0] nextAcc;
  logic             nextCarry, nextOvf, nextNeg, nextZero;

  assign widthMask = strobe.wide ? {WIDTH{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
  assign aMasked   = accIn & widthMask;
  assign bMasked   = (strobe.sub ? ~operand : operand) & widthMask;
  assign digitCarry[0] = carryIn;

  generate
    for (genvar d = 0; d < DIGITS; d++) begin : gDigit
      bcdDigit uDigit (
        .aNib    (aMasked[4*d +: 4]),
        .bNib    (bMasked[4*d +: 4]),
        .cin     (digitCarry[d]),
        .decimal (strobe.decimal),
        .sub     (strobe.sub),
        .rNib    (sumFull[4*d +: 4]),
        .partNib (partFull[4*d +: 4]),
        .cout    (digitCarry[d+1])
      );
    end
  endgenerate

  assign ovfSrc = strobe.decimal ? partFull : sumFull;
  assign ovfVec = (ovfSrc ^ aMasked) & (ovfSrc ^ bMasked);

  always_comb begin
    if (strobe.wide) begin
      nextAcc   = sumFull;
      nextCarry = digitCarry[DIGITS];
      nextOvf   = ovfVec[WIDTH-1];
      nextNeg   = sumFull[WIDTH-1];
      nextZero  = (sumFull == '0);
    end else begin
      nextAcc   = {accIn[WIDTH-1:HALF], sumFull[HALF-1:0]};
      nextCarry = digitCarry[HALFDIG];
      nextOvf   = ovfVec[HALF-1];
      nextNeg   = sumFull[HALF-1];
      nextZero  = (sumFull[HALF-1:0] == '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accOut      <= '0;
      carryOut    <= 1'b0;
      overflowOut <= 1'b0;
      negOut      <= 1'b0;
      zeroOut     <= 1'b0;
    end else if (strobe.load) begin
      accOut      <= nextAcc;
      carryOut    <= nextCarry;
      overflowOut <= nextOvf;
      negOut      <= nextNeg;
      zeroOut     <= nextZero;
    end
  end

  // R2
  hold_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(accOut) && $stable(carryOut) && $stable(overflowOut)
                      && $stable(negOut) && $stable(zeroOut)));
  // R11
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.wide) |=> (accOut[WIDTH-1:HALF] == $past(accIn[WIDTH-1:HALF])));
  // R10
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (negOut == ($past(strobe.wide) ? accOut[WIDTH-1] : accOut[HALF-1])));
  // R10
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (zeroOut == ($past(strobe.wide) ? (accOut == '0)
                                                     : (accOut[HALF-1:0] == '0))));
endmodule

// File: rtl/decAddSub.sv
module decAddSub
  import decAluPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [WIDTH-1:0] accIn,
  input  logic [WIDTH-1:0] operand,
  input  logic             carryIn,
  input  logic             decimalMode,
  input  logic             wideMode,
  input  logic             subtract,
  output logic             outValid,
  output logic [WIDTH-1:0] accOut,
  output logic             carryOut,
  output logic             overflowOut,
  output logic             negOut,
  output logic             zeroOut
);
  aluStrobeT strobe;

  aluCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .wideMode    (wideMode),
    .decimalMode (decimalMode),
    .subtract    (subtract),
    .strobe      (strobe),
    .outValid    (outValid)
  );

  aluDatapath #(.WIDTH(WIDTH)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .accIn       (accIn),
    .operand     (operand),
    .carryIn     (carryIn),
    .accOut      (accOut),
    .carryOut    (carryOut),
    .overflowOut (overflowOut),
    .negOut      (negOut),
    .zeroOut     (zeroOut)
  );
endmodule

// File: tb/sim_decAddSub.sv
module sim_decAddSub;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [15:0] accIn = '0, operand = '0;
  logic carryIn = 1'b0, decimalMode = 1'b0, wideMode = 1'b0, subtract = 1'b0;
  logic outValid;
  logic [15:0] accOut;
  logic carryOut, overflowOut, negOut, zeroOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] expAcc = '0;
  logic expC = 1'b0, expV = 1'b0, expN = 1'b0, expZ = 1'b0, expValid = 1'b0;
  string accTag = "R2", ovfTag = "R2";

  always #4 clk = ~clk;

  decAddSub u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .accIn(accIn), .operand(operand),
    .carryIn(carryIn), .decimalMode(decimalMode), .wideMode(wideMode), .subtract(subtract),
    .outValid(outValid), .accOut(accOut), .carryOut(carryOut), .overflowOut(overflowOut),
    .negOut(negOut), .zeroOut(zeroOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic refModel(input logic [15:0] a16, input logic [15:0] b16, input logic c,
                          input logic dec, input logic wide, input logic sub,
                          output logic [15:0] acc, output logic co, output logic vo,
                          output logic no, output logic zo);
    int mask, a, b, res, part, top, digits, m, cy;
    mask   = wide ? 32'hFFFF : 32'hFF;
    top    = wide ? 15 : 7;
    digits = wide ? 4 : 2;
    a      = int'(a16) & mask;
    b      = sub ? (~int'(b16)) & mask : int'(b16) & mask;
    part   = 0;
    if (!dec) begin
      res = a + b + int'(c);
      vo  = 1'((((res ^ a) & (res ^ b)) >> top) & 1);
    end else begin
      res = int'(c);
      for (int k = 0; k < digits; k++) begin
        m    = 15 << (4*k);
        cy   = 1 << (4*(k+1));
        res  = res + (a & m) + (b & m);
        part = part + (res & m);
        if (!sub) begin
          if (res >= (10 << (4*k))) res = ((res + (6 << (4*k))) & (cy - 1)) + cy;
        end else begin
          if (res < cy) res = (res - (6 << (4*k))) & (cy - 1);
          else          res = res & ((cy << 1) - 1);
        end
      end
      vo = 1'((((part ^ a) & (part ^ b)) >> top) & 1);
    end
    co  = 1'((res >> (top + 1)) & 1);
    acc = wide ? 16'(res) : {a16[15:8], 8'(res)};
    no  = 1'((res >> top) & 1);
    zo  = ((res & mask) == 0);
  endtask

  task automatic step(input logic v, input logic [15:0] a, input logic [15:0] b, input logic c,
                      input logic d, input logic w, input logic s);
    @(negedge clk);
    check("R1 outValid", int'(outValid), int'(expValid));
    check({accTag, " accOut"}, int'(accOut), int'(expAcc));
    check("R9 carryOut", int'(carryOut), int'(expC));
    check({ovfTag, " overflowOut"}, int'(overflowOut), int'(expV));
    check("R10 negOut", int'(negOut), int'(expN));
    check("R10 zeroOut", int'(zeroOut), int'(expZ));
    inValid = v; accIn = a; operand = b; carryIn = c;
    decimalMode = d; wideMode = w; subtract = s;
    expValid = v;
    if (v) begin
      refModel(a, b, c, d, w, s, expAcc, expC, expV, expN, expZ);
      accTag = d ? (s ? "R6" : "R5") : (s ? "R4" : "R3");
      ovfTag = d ? "R8" : "R7";
    end else begin
      accTag = "R2";
      ovfTag = "R2";
    end
  endtask

  task automatic directed(input logic [15:0] a, input logic [15:0] b, input logic c,
                          input logic d, input logic w, input logic s, input string tag,
                          input logic [15:0] eAcc, input logic eC);
    step(1'b1, a, b, c, d, w, s);
    @(posedge clk);
    #2;
    check({tag, " directed acc"}, int'(accOut), int'(eAcc));
    check({tag, " directed carry"}, int'(carryOut), int'(eC));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] ra, rb;
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 reset outValid", int'(outValid), 0);
    check("R13 reset accOut", int'(accOut), 0);
    check("R13 reset flags", int'({carryOut, overflowOut, negOut, zeroOut}), 0);
    rstN = 1'b1;

    // R5 8-bit decimal add 45+38 -> 83
    directed(16'h0045, 16'h0038, 1'b0, 1'b1, 1'b0, 1'b0, "R5", 16'h0083, 1'b0);
    // R6 8-bit decimal subtract 50-01 -> 49, no borrow
    directed(16'h0050, 16'h0001, 1'b1, 1'b1, 1'b0, 1'b1, "R6", 16'h0049, 1'b1);
    // R9 16-bit decimal 9999+0001 -> 0000 carry
    directed(16'h9999, 16'h0001, 1'b0, 1'b1, 1'b1, 1'b0, "R9", 16'h0000, 1'b1);
    // R11 and R7: 8-bit binary 7F+01 keeps AB upper
    directed(16'hAB7F, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, "R11", 16'hAB80, 1'b0);
    // R4 16-bit binary 0000-0001 -> FFFF with borrow
    directed(16'h0000, 16'h0001, 1'b1, 1'b0, 1'b1, 1'b1, "R4", 16'hFFFF, 1'b0);
    // R12 invalid digit 0F+00 -> 15
    directed(16'h000F, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, "R12", 16'h0015, 1'b0);
    // R2 idle cycles
    step(1'b0, 16'h1234, 16'h5678, 1'b1, 1'b0, 1'b1, 1'b0);
    step(1'b0, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b1);

    for (int i = 0; i < 4000; i++) begin
      ra = 16'($urandom);
      rb = 16'($urandom);
      if (($urandom % 2) == 0) begin
        ra = {4'(ra[15:12] % 10), 4'(ra[11:8] % 10), 4'(ra[7:4] % 10), 4'(ra[3:0] % 10)};
        rb = {4'(rb[15:12] % 10), 4'(rb[11:8] % 10), 4'(rb[7:4] % 10), 4'(rb[3:0] % 10)};
      end
      step(($urandom % 4) != 0, ra, rb, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule